// File: doc/BRIEF.md
# Counterflow Banded Matrix-Vector Systolic Array

This block computes the product of a band matrix and a vector, y = A·x + b, with a straight row of identical multiply-accumulate cells. The number of cells equals the band width w = SUB_DIAG + SUPER_DIAG + 1. Vector elements enter at the left end and step one cell to the right every clock. Partial sums enter at the right end, usually as zero or as a bias b, and step one cell to the left every clock. Each cell talks only to its two neighbours. Matrix coefficients do not travel along the row: every cell has its own coefficient input, which the host drives on a fixed diagonal timetable.

Successive vector elements, and successive partial sums, are placed two cycles apart. A pair of elements moving in opposite directions therefore meets in exactly one cell. A cell adds its coefficient times the passing x only when a valid x and a valid partial sum both sit at its inputs. Finished results leave the left end in row order, each with a valid strobe. Every x also leaves the right end unchanged, so it can be reused downstream. A band product of n rows completes in about 2n + w cycles.

Top module: `band_mv_array`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline register is cleared. From the next cycle `y_out_valid` and `x_out_valid` are 0 and `y_out_data` and `x_out_data` are 0.
- R2: An x driven with `x_in_valid` in cycle t appears unchanged on `x_out_data`, with `x_out_valid` high, in cycle t+W, where W = SUB_DIAG+SUPER_DIAG+1.
- R3: A partial sum driven with `y_in_valid` in cycle t, meeting no valid x, appears unchanged on `y_out_data`, with `y_out_valid` high, in cycle t+W.
- R4: Cell k (k = 0 at the x-entry end, k = W-1 at the y-entry end) takes its coefficient from `a_in[k*DATA_W +: DATA_W]`. An x driven in cycle tx reaches cell k's inputs in cycle tx+k. A y driven in cycle ty reaches cell k's inputs in cycle ty+W-1-k. If both arrive in the same cycle, the y emerging in cycle ty+W equals y + a_k·x.
- R5: A cell's coefficient has no effect in any cycle in which the cell does not hold both a valid x and a valid y.
- R6: Drive x_j in cycle 2j+SUB_DIAG, bias b_i in cycle 2i+SUPER_DIAG, and A[i][i+SUPER_DIAG-k] on cell k's slice in cycle 2i+SUPER_DIAG+W-1-k. Then `y_out_data` = b_i + Σ_j A[i][j]·x_j over the band, with `y_out_valid` high, in cycle 2i+SUPER_DIAG+W. Results come out in increasing row order.
- R7: All arithmetic is two's-complement signed. The partial-sum width is ACC_W = 2·DATA_W + clog2(W) + 1, so W products of the most negative value by itself, added to any bias of magnitude up to 2^(2·DATA_W+clog2(W)-1), never wrap.
- R8: A reset applied while values are in flight discards them. No valid strobe from values entered before the reset appears afterwards.
- R9: Successive valid strobes on `x_in_valid`, and successive strobes on `y_in_valid`, must have at least one idle cycle between them. When they do, `y_out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every cell |
| rst | input | 1 | Synchronous reset, active high |
| x_in_data | input | DATA_W | Vector element entering the left end (signed) |
| x_in_valid | input | 1 | Qualifies `x_in_data` |
| y_in_data | input | ACC_W | Partial sum or bias entering the right end (signed) |
| y_in_valid | input | 1 | Qualifies `y_in_data` |
| a_in | input | W*DATA_W | Per-cell coefficients, cell k in slice k (signed each) |
| x_out_data | output | DATA_W | Vector element leaving the right end |
| x_out_valid | output | 1 | Qualifies `x_out_data` |
| y_out_data | output | ACC_W | Finished result leaving the left end (signed) |
| y_out_valid | output | 1 | Qualifies `y_out_data` |

## Verification
Every path through the array is exactly W register stages long. The bench therefore expects a y entered in cycle t at the left end in cycle t+W, and an x entered in cycle t at the right end in cycle t+W. For a banded run, row i is due in cycle 2i+SUPER_DIAG+W. Each scenario task counts cycles from its own first drive. It samples the outputs on the falling edge, before it drives that cycle's inputs, so observation c shows the effect of every input up to cycle c-1. For every cycle, the task checks either the computed value or the absence of a valid strobe.

// File: rtl/band_mv_pkg.sv
package band_mv_pkg;

   typedef enum logic [0:0] {
      MULT_NATIVE    = 1'b0,
      MULT_SHIFT_ADD = 1'b1
   } mult_style_e;

   // Partial-sum width: full product, growth for each band term, one spare bit.
   function automatic int acc_width(input int data_w, input int cells);
      return 2 * data_w + $clog2(cells) + 1;
   endfunction

endpackage

// File: rtl/band_mv_mult.sv
module band_mv_mult #(
   parameter int                       DATA_W = 8,
   parameter band_mv_pkg::mult_style_e STYLE  = band_mv_pkg::MULT_NATIVE
) (
   input  logic signed [DATA_W-1:0]   a_i,
   input  logic signed [DATA_W-1:0]   b_i,
   output logic signed [2*DATA_W-1:0] p_o
);

   localparam int PW = 2 * DATA_W;

   if (DATA_W < 2) begin : g_chk_dw
      $error("band_mv_mult: DATA_W must be at least 2");
   end

   if (STYLE == band_mv_pkg::MULT_NATIVE) begin : g_native
      assign p_o = a_i * b_i;
   end else begin : g_shift_add
      logic signed [PW-1:0]         a_ext;
      logic [DATA_W:0][PW-1:0]      part;

      assign a_ext   = {{DATA_W{a_i[DATA_W-1]}}, a_i};
      assign part[0] = '0;

      for (genvar g = 0; g < DATA_W; g++) begin : g_row
         logic [PW-1:0] row;
         assign row = b_i[g] ? (a_ext <<< g) : '0;
         // the sign bit of b carries negative weight
         if (g == DATA_W - 1) begin : g_neg
            assign part[g+1] = part[g] - row;
         end else begin : g_pos
            assign part[g+1] = part[g] + row;
         end
      end

      assign p_o = $signed(part[DATA_W]);
   end

endmodule

// File: rtl/band_mv_cell.sv
module band_mv_cell #(
   parameter int                       DATA_W     = 8,
   parameter int                       ACC_W      = 19,
   parameter band_mv_pkg::mult_style_e MULT_STYLE = band_mv_pkg::MULT_NATIVE
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] x_i,
   input  logic                     xv_i,
   input  logic signed [ACC_W-1:0]  y_i,
   input  logic                     yv_i,
   input  logic signed [DATA_W-1:0] a_i,
   output logic signed [DATA_W-1:0] x_o,
   output logic                     xv_o,
   output logic signed [ACC_W-1:0]  y_o,
   output logic                     yv_o
);

   localparam int PW  = 2 * DATA_W;
   localparam int EXT = ACC_W - PW;

   if (EXT < 1) begin : g_chk_acc
      $error("band_mv_cell: ACC_W must exceed twice DATA_W");
   end

   logic signed [PW-1:0]    prod;
   logic                    pair;
   logic signed [ACC_W-1:0] term;
   logic [ACC_W:0]          sum_w;

   band_mv_mult #(
      .DATA_W (DATA_W),
      .STYLE  (MULT_STYLE)
   ) mult_i (
      .a_i (a_i),
      .b_i (x_i),
      .p_o (prod)
   );

   // only a real x meeting a real y may contribute
   assign pair  = xv_i & yv_i;
   assign term  = pair ? {{EXT{prod[PW-1]}}, prod} : '0;
   assign sum_w = {y_i[ACC_W-1], y_i} + {term[ACC_W-1], term};

   always_ff @(posedge clk) begin
      if (rst) begin
         x_o  <= '0;
         xv_o <= 1'b0;
         y_o  <= '0;
         yv_o <= 1'b0;
      end else begin
         x_o  <= x_i;
         xv_o <= xv_i;
         y_o  <= sum_w[ACC_W-1:0];
         yv_o <= yv_i;
      end
   end

   // R7: the widened partial sum never wraps
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      sum_w[ACC_W] == sum_w[ACC_W-1]);

   // R5: without a meeting pair the sum crosses the cell untouched
   p_bubble_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !(xv_i && yv_i) |=> (y_o == $past(y_i)));

endmodule

// File: rtl/band_mv_array.sv
module band_mv_array #(
   parameter int                       DATA_W     = 8,
   parameter int                       SUB_DIAG   = 1,
   parameter int                       SUPER_DIAG = 2,
   parameter band_mv_pkg::mult_style_e MULT_STYLE = band_mv_pkg::MULT_NATIVE,
   localparam int                      W          = SUB_DIAG + SUPER_DIAG + 1,
   localparam int                      ACC_W      = band_mv_pkg::acc_width(DATA_W, W)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] x_in_data,
   input  logic                     x_in_valid,
   input  logic signed [ACC_W-1:0]  y_in_data,
   input  logic                     y_in_valid,
   input  logic [W*DATA_W-1:0]      a_in,
   output logic signed [DATA_W-1:0] x_out_data,
   output logic                     x_out_valid,
   output logic signed [ACC_W-1:0]  y_out_data,
   output logic                     y_out_valid
);

   localparam int OCC_W = $clog2(W + 2);

   if (DATA_W < 2) begin : g_chk_dw
      $error("band_mv_array: DATA_W must be at least 2");
   end
   if (SUB_DIAG < 0 || SUPER_DIAG < 0) begin : g_chk_band
      $error("band_mv_array: diagonal counts must not be negative");
   end

   // link k sits between cell k-1 and cell k; link 0 and link W are the ends
   logic signed [DATA_W-1:0] x_link  [0:W];
   logic                     xv_link [0:W];
   logic signed [ACC_W-1:0]  y_link  [0:W];
   logic                     yv_link [0:W];

   assign x_link[0]  = x_in_data;
   assign xv_link[0] = x_in_valid;
   assign y_link[W]  = y_in_data;
   assign yv_link[W] = y_in_valid;

   for (genvar k = 0; k < W; k++) begin : g_cell
      band_mv_cell #(
         .DATA_W     (DATA_W),
         .ACC_W      (ACC_W),
         .MULT_STYLE (MULT_STYLE)
      ) cell_i (
         .clk  (clk),
         .rst  (rst),
         .x_i  (x_link[k]),
         .xv_i (xv_link[k]),
         .y_i  (y_link[k+1]),
         .yv_i (yv_link[k+1]),
         .a_i  ($signed(a_in[k*DATA_W +: DATA_W])),
         .x_o  (x_link[k+1]),
         .xv_o (xv_link[k+1]),
         .y_o  (y_link[k]),
         .yv_o (yv_link[k])
      );
   end

   assign x_out_data  = x_link[W];
   assign x_out_valid = xv_link[W];
   assign y_out_data  = y_link[0];
   assign y_out_valid = yv_link[0];

   // partial sums inside the row, used only by the checks below
   logic [OCC_W-1:0] occ;
   always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else     occ <= occ + OCC_W'(y_in_valid) - OCC_W'(y_out_valid);
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!y_out_valid && !x_out_valid));

   p_x_spacing_r9: assert property (@(posedge clk) disable iff (rst)
      x_in_valid |=> !x_in_valid);

   p_y_spacing_r9: assert property (@(posedge clk) disable iff (rst)
      y_in_valid |=> !y_in_valid);

   p_out_spacing_r9: assert property (@(posedge clk) disable iff (rst)
      y_out_valid |=> !y_out_valid);

   // R3: no partial sum is lost or duplicated on its way across
   p_occupancy_r3: assert property (@(posedge clk) disable iff (rst)
      occ <= OCC_W'(W));

endmodule

// File: tb/band_mv_array_tb.sv
module band_mv_array_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 8;
   localparam int P     = 1;
   localparam int Q     = 2;
   localparam int W     = P + Q + 1;
   localparam int AW    = 2 * DW + $clog2(W) + 1;
   localparam int NMAX  = 8;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic signed [DW-1:0] x_in_data  = '0;
   logic                 x_in_valid = 1'b0;
   logic signed [AW-1:0] y_in_data  = '0;
   logic                 y_in_valid = 1'b0;
   logic [W*DW-1:0]      a_in       = '0;
   logic signed [DW-1:0] x_out_data;
   logic                 x_out_valid;
   logic signed [AW-1:0] y_out_data;
   logic                 y_out_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int mat  [0:NMAX-1][0:NMAX-1];
   int xvec [0:NMAX-1];
   int bias [0:NMAX-1];
   int nrows;

   always #(CLK_PERIOD/2) clk = ~clk;

   band_mv_array #(
      .DATA_W     (DW),
      .SUB_DIAG   (P),
      .SUPER_DIAG (Q)
   ) dut_i (
      .clk         (clk),
      .rst         (rst),
      .x_in_data   (x_in_data),
      .x_in_valid  (x_in_valid),
      .y_in_data   (y_in_data),
      .y_in_valid  (y_in_valid),
      .a_in        (a_in),
      .x_out_data  (x_out_data),
      .x_out_valid (x_out_valid),
      .y_out_data  (y_out_data),
      .y_out_valid (y_out_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      x_in_data  = '0;
      x_in_valid = 1'b0;
      y_in_data  = '0;
      y_in_valid = 1'b0;
      a_in       = '0;
   endtask

   function automatic int row_result(input int i);
      int s = bias[i];
      for (int j = 0; j < nrows; j++)
         if (j >= i - P && j <= i + Q) s += mat[i][j] * xvec[j];
      return s;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check(y_out_valid == 1'b0, "R1", "y_out_valid after reset", y_out_valid, 0);
      check(x_out_valid == 1'b0, "R1", "x_out_valid after reset", x_out_valid, 0);
      check(y_out_data == '0, "R1", "y_out_data after reset", y_out_data, 0);
      check(x_out_data == '0, "R1", "x_out_data after reset", x_out_data, 0);
   endtask

   // R3/R5: sums without any x, coefficients held at nonzero values
   task automatic t_passthrough();
      int vals [0:2] = '{-5, 1234, -70000};
      for (int c = 0; c <= 4 + W + 1; c++) begin
         @(negedge clk);
         if (c >= W && (c - W) % 2 == 0 && (c - W) / 2 < 3) begin
            int e = vals[(c - W) / 2];
            check(y_out_valid == 1'b1, "R3", "pass valid", y_out_valid, 1);
            check(int'(y_out_data) == e, "R5", "pass value with idle coefficients",
                  int'(y_out_data), e);
         end
         check(x_out_valid == 1'b0, "R3", "no x leaves", x_out_valid, 0);
         idle_inputs();
         for (int k = 0; k < W; k++) a_in[k*DW +: DW] = DW'(8'sd127 - k);
         if (c % 2 == 0 && c / 2 < 3) begin
            y_in_data  = AW'(vals[c / 2]);
            y_in_valid = 1'b1;
         end
      end
      idle_inputs();
   endtask

   // R4/R2/R5: one x meets one y in cell k only; other cells see other coefficients
   task automatic t_single_cell();
      for (int k = 0; k < W; k++) begin
         int ty = W;
         int tx = 2 * W - 1 - 2 * k;
         int ak = -3 - 2 * k;
         for (int c = 0; c <= 3 * W + 1; c++) begin
            @(negedge clk);
            if (c == ty + W) begin
               check(y_out_valid == 1'b1, "R4", "meet valid", y_out_valid, 1);
               check(int'(y_out_data) == 100 + ak * 7, "R4", "single-cell product",
                     int'(y_out_data), 100 + ak * 7);
            end
            if (c == tx + W) begin
               check(x_out_valid == 1'b1 && int'(x_out_data) == 7, "R2",
                     "x forwarded unchanged", int'(x_out_data), 7);
            end
            idle_inputs();
            for (int m = 0; m < W; m++)
               a_in[m*DW +: DW] = (m == k) ? DW'(ak) : DW'(9);
            if (c == tx) begin
               x_in_data  = 8'sd7;
               x_in_valid = 1'b1;
            end
            if (c == ty) begin
               y_in_data  = AW'(100);
               y_in_valid = 1'b1;
            end
         end
         idle_inputs();
      end
   endtask

   // R6/R9 (and R7 when filled with extremes): full diagonal timetable
   task automatic run_band(input string req, input bit garbage);
      int last = 2 * nrows + Q + W + 2;
      int seen = 0;
      bit prev = 1'b0;
      for (int c = 0; c <= last; c++) begin
         int r;
         @(negedge clk);
         r = c - Q - W;
         if (r >= 0 && r % 2 == 0 && r / 2 < nrows) begin
            int e = row_result(r / 2);
            check(y_out_valid == 1'b1, req, "row valid", y_out_valid, 1);
            check(int'(y_out_data) == e, req, $sformatf("row %0d value", r / 2),
                  int'(y_out_data), e);
         end else begin
            check(y_out_valid == 1'b0, req, "no stray result", y_out_valid, 0);
         end
         if (y_out_valid) begin
            seen++;
            check(!prev, "R9", "back-to-back results", 1, 0);
         end
         prev = y_out_valid;
         idle_inputs();
         if (c >= P && (c - P) % 2 == 0 && (c - P) / 2 < nrows) begin
            x_in_data  = DW'(xvec[(c - P) / 2]);
            x_in_valid = 1'b1;
         end
         if (c >= Q && (c - Q) % 2 == 0 && (c - Q) / 2 < nrows) begin
            y_in_data  = AW'(bias[(c - Q) / 2]);
            y_in_valid = 1'b1;
         end
         for (int k = 0; k < W; k++) begin
            int i2 = c - Q - (W - 1) + k;
            int v  = garbage ? 55 : 0;
            if (i2 >= 0 && i2 % 2 == 0 && i2 / 2 < nrows) begin
               int i = i2 / 2;
               int j = i + Q - k;
               if (j >= 0 && j < nrows) v = mat[i][j];
            end
            a_in[k*DW +: DW] = DW'(v);
         end
      end
      idle_inputs();
      check(seen == nrows, req, "result count", seen, nrows);
   endtask

   task automatic t_band();
      nrows = 6;
      for (int i = 0; i < NMAX; i++) begin
         xvec[i] = (i * 7) % 13 - 6;
         bias[i] = i * 10 - 20;
         for (int j = 0; j < NMAX; j++)
            mat[i][j] = (j >= i - P && j <= i + Q) ? ((i * 3 + j * 5) % 11) - 5 : 0;
      end
      run_band("R6", 1'b1);
   endtask

   task automatic t_extremes();
      nrows = 5;
      for (int i = 0; i < NMAX; i++) begin
         xvec[i] = -128;
         bias[i] = -100000;
         for (int j = 0; j < NMAX; j++)
            mat[i][j] = (j >= i - P && j <= i + Q) ? -128 : 0;
      end
      run_band("R7", 1'b0);
   endtask

   task automatic t_reset_mid();
      for (int c = 0; c <= 4 + 2 * W; c++) begin
         @(negedge clk);
         if (c >= 4) begin
            check(y_out_valid == 1'b0 && x_out_valid == 1'b0, "R8",
                  "valid after mid-stream reset", y_out_valid | x_out_valid, 0);
            check(y_out_data == '0, "R8", "sum after mid-stream reset",
                  int'(y_out_data), 0);
         end
         idle_inputs();
         rst = (c == 3);
         if (c == 0 || c == 2) begin
            x_in_data  = 8'sd11;
            x_in_valid = 1'b1;
            y_in_data  = AW'(500);
            y_in_valid = 1'b1;
            for (int k = 0; k < W; k++) a_in[k*DW +: DW] = DW'(4);
         end
      end
      rst = 1'b0;
      idle_inputs();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_passthrough();
      t_single_cell();
      t_band();
      t_extremes();
      t_reset_mid();
      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R6 watchdog expired: actual %0d expected %0d", 100000, 0);
         summary();
         $finish;
      end
   end

endmodule